// File: doc/BRIEF.md
# Shadow Tag Snoop Filter

This block keeps duplicate copies of the tags of every private L2 cache in a small cluster of cores. A request from one core is checked against these copies before the shared cache may look up the line. If another core's L2 holds the line, the request is sent to that core as a cache-to-cache transfer. Otherwise the block lets the shared cache proceed. Each L2 reports every fill and every eviction on its own update port. The copies therefore stay current without the L2 tag arrays being probed.

The copies are held in four banks, one per L2 way. A lookup walks the banks one per cycle. It starts at the bank picked by the two low bits of the set index and wraps around. Within each bank, a cheap partial-tag compare runs first. Only a bank whose partial tags match a candidate costs a second cycle for the full-tag compare. Requests are handled strictly one at a time. The shared-cache go-ahead appears only after all four banks have been checked without a hit.

Top module: `sf_snoop_filter`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `fwd_valid` and `proceed` are 0. All shadow entries are invalid.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the cycle after `done`. It is 1 again in the cycle that follows `done`.
- R3: An update with fill = 1 makes entry (core, set, way) valid with the given tag. An update with fill = 0 invalidates that entry. A lookup that starts after the update edge reflects the change.
- R4: A line address is split into a set index (the low `IDX_W` bits) and a tag (the remaining upper bits). Way w of every core lives in bank w. A lookup visits the banks in the order s, s+1, s+2, s+3 modulo 4, where s is the set index modulo 4.
- R5: A visited bank costs one cycle. It costs two cycles if any valid entry of another core in that set matches the low `PT_W` tag bits. `done` is seen exactly (sum of bank costs) clock edges after the acceptance edge.
- R6: A partial-tag match whose full tag differs never causes a forward.
- R7: The forward target comes from the first bank, in visiting order, that holds a full match. Within that bank the lowest-numbered matching core wins. The lookup stops at that bank.
- R8: Entries of the requesting core are ignored. They neither add a full-compare cycle nor cause a forward.
- R9: `done` is high for one cycle, with exactly one of `fwd_valid` or `proceed` set. `proceed` is given only after all four banks have been searched without a hit. Both are 0 whenever `done` is 0.
- R10: An update to the set of an in-flight lookup restarts the walk from its start bank, so the result reflects the update. An update to a different set does not change the lookup's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_core | input | ID_W | Requesting core |
| req_line | input | LINE_W | Requested line address |
| req_ready | output | 1 | Filter idle, able to accept |
| upd_valid | input | CORES | Per-core tag update strobe |
| upd_fill | input | CORES | 1 = fill, 0 = eviction |
| upd_line | input | CORES*LINE_W | Per-core updated line address |
| upd_way | input | CORES*2 | Per-core updated way (selects bank) |
| done | output | 1 | Lookup finished (one cycle) |
| fwd_valid | output | 1 | Forward to another core's L2 |
| fwd_core | output | ID_W | Core to forward to |
| proceed | output | 1 | Shared cache may look up the line |

## Verification
Several rules are checked by the assertions on every cycle: the one-cycle `done` that carries exactly one result, quiet outputs between results, serialization of requests through `req_ready`, and never forwarding to the requester. The bench scenarios are the only way to show the rest. These are which core is chosen, the bank walk order and the partial-versus-full cycle cost behind the exact latency, and correct results after fills and evictions. They also cover the restart when a same-set update lands in the middle of a walk. A reference model of the shadow contents in the bench predicts both the result and the latency of every lookup.

// File: rtl/sf_pkg.sv
package sf_pkg;
    localparam int BANKS  = 4;
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PART,
        ST_FULL,
        ST_RESP
    } sf_state_e;
endpackage

// File: rtl/sf_tag_bank.sv
module sf_tag_bank #(
    parameter int CORES = 4,
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(SETS),
    parameter int TAG_W = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CORES-1:0]         wr_en,
    input  logic [CORES-1:0]         wr_fill,
    input  logic [CORES*IDX_W-1:0]   wr_set,
    input  logic [CORES*TAG_W-1:0]   wr_tag,
    input  logic [IDX_W-1:0]         rd_set,
    output logic [CORES*TAG_W-1:0]   rd_tag,
    output logic [CORES-1:0]         rd_vld
);
    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vlds;
        logic [IDX_W-1:0] widx;

        assign widx = wr_set[c*IDX_W +: IDX_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vlds <= '0;
            else if (wr_en[c])
                vlds[widx] <= wr_fill[c];
        end

        always_ff @(posedge clk) begin
            if (wr_en[c] && wr_fill[c])
                tags[widx] <= wr_tag[c*TAG_W +: TAG_W];
        end

        assign rd_tag[c*TAG_W +: TAG_W] = tags[rd_set];
        assign rd_vld[c]                = vlds[rd_set];
    end
endmodule

// File: rtl/sf_match.sv
module sf_match #(
    parameter int CORES = 4,
    parameter int ID_W  = $clog2(CORES),
    parameter int TAG_W = 22,
    parameter int PT_W  = 6
) (
    input  logic [CORES*TAG_W-1:0] ent_tag,
    input  logic [CORES-1:0]       ent_vld,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [ID_W-1:0]        req_core,
    output logic [CORES-1:0]       part_hit,
    output logic [CORES-1:0]       full_hit
);
    for (genvar c = 0; c < CORES; c++) begin : g_cmp
        logic [TAG_W-1:0] t;
        assign t           = ent_tag[c*TAG_W +: TAG_W];
        assign part_hit[c] = ent_vld[c] && (ID_W'(c) != req_core)
                             && (t[PT_W-1:0] == req_tag[PT_W-1:0]);
        assign full_hit[c] = ent_vld[c] && (t == req_tag);
    end
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
    import sf_pkg::*;
#(
    parameter int CORES = 4,
    parameter int ID_W  = $clog2(CORES),
    parameter int IDX_W = 4,
    parameter int TAG_W = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ID_W-1:0]      req_core,
    input  logic [IDX_W-1:0]     req_set,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [CORES-1:0]     part_hit,
    input  logic [CORES-1:0]     full_hit,
    input  logic                 upd_same_set,
    output logic [BANK_W-1:0]    rd_bank,
    output logic [IDX_W-1:0]     cur_set,
    output logic [TAG_W-1:0]     cur_tag,
    output logic [ID_W-1:0]      cur_core,
    output logic                 req_ready,
    output logic                 done,
    output logic                 fwd_valid,
    output logic [ID_W-1:0]      fwd_core,
    output logic                 proceed
);
    sf_state_e         state_q, state_d;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] seen_q;
    logic [CORES-1:0]  cand_q;
    logic              res_fwd_q;
    logic [ID_W-1:0]   res_core_q;
    logic [CORES-1:0]  win;
    logic              last_bank, restart;

    function automatic logic [ID_W-1:0] lowest(input logic [CORES-1:0] m);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = CORES - 1; i >= 0; i--)
            if (m[i]) r = ID_W'(i);
        return r;
    endfunction

    assign win       = full_hit & cand_q;
    assign last_bank = (seen_q == BANK_W'(BANKS - 1));
    assign restart   = upd_same_set && (state_q == ST_PART || state_q == ST_FULL);
    assign rd_bank   = bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)      state_d = ST_PART;
            ST_PART: begin
                if (restart)             state_d = ST_PART;
                else if (|part_hit)      state_d = ST_FULL;
                else if (last_bank)      state_d = ST_RESP;
            end
            ST_FULL: begin
                if (restart)             state_d = ST_PART;
                else if (|win)           state_d = ST_RESP;
                else if (last_bank)      state_d = ST_RESP;
                else                     state_d = ST_PART;
            end
            ST_RESP:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            seen_q     <= '0;
            cand_q     <= '0;
            cur_set    <= '0;
            cur_tag    <= '0;
            cur_core   <= '0;
            res_fwd_q  <= 1'b0;
            res_core_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cur_set  <= req_set;
                    cur_tag  <= req_tag;
                    cur_core <= req_core;
                    bank_q   <= req_set[BANK_W-1:0];
                    seen_q   <= '0;
                end
                ST_PART: begin
                    if (restart) begin
                        bank_q <= cur_set[BANK_W-1:0];
                        seen_q <= '0;
                    end else if (|part_hit) begin
                        cand_q <= part_hit;
                    end else if (last_bank) begin
                        res_fwd_q <= 1'b0;
                    end else begin
                        bank_q <= bank_q + 1'b1;
                        seen_q <= seen_q + 1'b1;
                    end
                end
                ST_FULL: begin
                    if (restart) begin
                        bank_q <= cur_set[BANK_W-1:0];
                        seen_q <= '0;
                    end else if (|win) begin
                        res_fwd_q  <= 1'b1;
                        res_core_q <= lowest(win);
                    end else if (last_bank) begin
                        res_fwd_q <= 1'b0;
                    end else begin
                        bank_q <= bank_q + 1'b1;
                        seen_q <= seen_q + 1'b1;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_RESP);
        fwd_valid = done && res_fwd_q;
        proceed   = done && !res_fwd_q;
        fwd_core  = res_core_q;
    end
endmodule

// File: rtl/sf_snoop_filter.sv
module sf_snoop_filter
    import sf_pkg::*;
#(
    parameter int CORES  = 4,
    parameter int SETS   = 16,
    parameter int LINE_W = 26,
    parameter int PT_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [$clog2(CORES)-1:0]      req_core,
    input  logic [LINE_W-1:0]             req_line,
    output logic                          req_ready,
    input  logic [CORES-1:0]              upd_valid,
    input  logic [CORES-1:0]              upd_fill,
    input  logic [CORES*LINE_W-1:0]       upd_line,
    input  logic [CORES*BANK_W-1:0]       upd_way,
    output logic                          done,
    output logic                          fwd_valid,
    output logic [$clog2(CORES)-1:0]      fwd_core,
    output logic                          proceed
);
    localparam int ID_W  = $clog2(CORES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LINE_W - IDX_W;

    logic [CORES*IDX_W-1:0] u_set;
    logic [CORES*TAG_W-1:0] u_tag;
    logic [CORES-1:0]       u_same;
    logic [CORES*TAG_W-1:0] bank_tag [BANKS];
    logic [CORES-1:0]       bank_vld [BANKS];
    logic [BANK_W-1:0]      rd_bank;
    logic [IDX_W-1:0]       cur_set;
    logic [TAG_W-1:0]       cur_tag;
    logic [ID_W-1:0]        cur_core;
    logic [CORES-1:0]       part_hit, full_hit;

    for (genvar c = 0; c < CORES; c++) begin : g_upd
        assign u_set[c*IDX_W +: IDX_W] = upd_line[c*LINE_W +: IDX_W];
        assign u_tag[c*TAG_W +: TAG_W] = upd_line[c*LINE_W + IDX_W +: TAG_W];
        assign u_same[c] = upd_valid[c] && (upd_line[c*LINE_W +: IDX_W] == cur_set);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CORES-1:0] wr_en;
        for (genvar c = 0; c < CORES; c++) begin : g_sel
            assign wr_en[c] = upd_valid[c] && (upd_way[c*BANK_W +: BANK_W] == BANK_W'(b));
        end
        sf_tag_bank #(
            .CORES(CORES), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_fill (upd_fill),
            .wr_set  (u_set),
            .wr_tag  (u_tag),
            .rd_set  (cur_set),
            .rd_tag  (bank_tag[b]),
            .rd_vld  (bank_vld[b])
        );
    end

    sf_match #(
        .CORES(CORES), .ID_W(ID_W), .TAG_W(TAG_W), .PT_W(PT_W)
    ) u_match (
        .ent_tag  (bank_tag[rd_bank]),
        .ent_vld  (bank_vld[rd_bank]),
        .req_tag  (cur_tag),
        .req_core (cur_core),
        .part_hit (part_hit),
        .full_hit (full_hit)
    );

    sf_ctrl #(
        .CORES(CORES), .ID_W(ID_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_core     (req_core),
        .req_set      (req_line[IDX_W-1:0]),
        .req_tag      (req_line[LINE_W-1:IDX_W]),
        .part_hit     (part_hit),
        .full_hit     (full_hit),
        .upd_same_set (|u_same),
        .rd_bank      (rd_bank),
        .cur_set      (cur_set),
        .cur_tag      (cur_tag),
        .cur_core     (cur_core),
        .req_ready    (req_ready),
        .done         (done),
        .fwd_valid    (fwd_valid),
        .fwd_core     (fwd_core),
        .proceed      (proceed)
    );
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
    parameter int ID_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [ID_W-1:0] req_core,
    input logic            done,
    input logic            fwd_valid,
    input logic [ID_W-1:0] fwd_core,
    input logic            proceed
);
    logic            pend_q;
    logic [ID_W-1:0] own_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            own_q  <= '0;
        end else if (req_valid && req_ready) begin
            pend_q <= 1'b1;
            own_q  <= req_core;
        end else if (done) begin
            pend_q <= 1'b0;
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fwd_valid != proceed)); // R9
    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!fwd_valid && !proceed)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R2
    AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !req_ready); // R2
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pend_q); // R2
    AST_NO_SELF_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_core != own_q)); // R8
endmodule

bind sf_snoop_filter sf_checker #(.ID_W($clog2(CORES))) u_sf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_core  (req_core),
    .done      (done),
    .fwd_valid (fwd_valid),
    .fwd_core  (fwd_core),
    .proceed   (proceed)
);

// File: tb/test_sf_snoop_filter.sv
module test_sf_snoop_filter;
    localparam int CORES = 4, SETS = 16, LINE_W = 26, PT_W = 6;
    localparam int IDX_W = 4, TAG_W = 22;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic [1:0]              req_core = '0;
    logic [LINE_W-1:0]       req_line = '0;
    logic                    req_ready;
    logic [CORES-1:0]        upd_valid = '0;
    logic [CORES-1:0]        upd_fill = '0;
    logic [CORES*LINE_W-1:0] upd_line = '0;
    logic [CORES*2-1:0]      upd_way = '0;
    logic                    done, fwd_valid, proceed;
    logic [1:0]              fwd_core;

    int n_chk = 0, n_fail = 0;
    logic [TAG_W-1:0] m_tag [CORES][SETS][4];
    bit               m_vld [CORES][SETS][4];
    int seed = 32'h5eed_0042;

    always #5 clk = ~clk;

    sf_snoop_filter i_sf_snoop_filter (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Expected result: fwd (1/0), target core, latency in clock edges.
    task automatic model(input int rc, input logic [TAG_W-1:0] tg, input int st,
                         output bit fwd, output int tgt, output int lat);
        fwd = 0; tgt = 0; lat = 0;
        for (int k = 0; k < 4; k++) begin
            int b;
            bit pm;
            b = (st + k) % 4;
            pm = 0;
            lat++;
            for (int c = 0; c < CORES; c++)
                if (c != rc && m_vld[c][st][b] && m_tag[c][st][b][PT_W-1:0] == tg[PT_W-1:0])
                    pm = 1;
            if (pm) begin
                lat++;
                for (int c = CORES - 1; c >= 0; c--)
                    if (c != rc && m_vld[c][st][b] && m_tag[c][st][b] == tg) begin
                        fwd = 1; tgt = c;
                    end
                if (fwd) return;
            end
        end
    endtask

    task automatic upd(input int c, input bit fill, input logic [TAG_W-1:0] tg,
                       input int st, input int way);
        @(negedge clk);
        upd_valid[c] = 1'b1;
        upd_fill[c]  = fill;
        upd_line[c*LINE_W +: LINE_W] = {tg, 4'(st)};
        upd_way[c*2 +: 2] = 2'(way);
        @(posedge clk);
        m_vld[c][st][way] = fill;
        if (fill) m_tag[c][st][way] = tg;
        @(negedge clk);
        upd_valid = '0;
    endtask

    // Start request; returns after the acceptance edge, at the following negedge.
    task automatic issue(input int rc, input logic [TAG_W-1:0] tg, input int st);
        @(negedge clk);
        chk(req_ready === 1'b1, "R2 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_core  = 2'(rc);
        req_line  = {tg, 4'(st)};
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R2 busy after accept", int'(req_ready), 0);
    endtask

    task automatic wait_done(output int cnt);
        cnt = 0;
        while (done !== 1'b1 && cnt < 60) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic check_res(input string rq, input bit efwd, input int etgt);
        chk(done === 1'b1, {rq, " done"}, int'(done), 1);
        chk(fwd_valid === efwd && proceed === !efwd, {rq, " R9 fwd/proceed"},
            int'(fwd_valid), int'(efwd));
        if (efwd) chk(int'(fwd_core) == etgt, {rq, " R7 target core"}, int'(fwd_core), etgt);
    endtask

    task automatic lookup(input int rc, input logic [TAG_W-1:0] tg, input int st,
                          input string rq);
        bit efwd; int etgt, elat, cnt;
        model(rc, tg, st, efwd, etgt, elat);
        issue(rc, tg, st);
        wait_done(cnt);
        check_res(rq, efwd, etgt);
        chk(cnt == elat, {rq, " R5 R4 latency"}, cnt, elat);
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0, "R2 ready after done", int'(req_ready), 1);
    endtask

    function automatic logic [TAG_W-1:0] rnd_tag();
        logic [15:0] hi;
        logic [5:0]  lo;
        hi = 16'h1000 + 16'($urandom % 3);
        lo = ($urandom % 2) ? 6'h15 : 6'h2a;
        return {hi, lo};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        int sets [4] = '{0, 1, 6, 11};
        logic [TAG_W-1:0] ta, tb, tp;
        bit efwd; int etgt, elat, cnt;
        void'($urandom(seed));
        for (int c = 0; c < CORES; c++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < 4; w++) m_vld[c][s][w] = 0;

        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        chk(done === 1'b0 && fwd_valid === 1'b0 && proceed === 1'b0, "R1 outputs idle",
            int'(done), 0);
        rst_n = 1'b1;

        ta = {16'h1000, 6'h15};
        tb = {16'h1002, 6'h15};
        tp = {16'h1001, 6'h15};
        // R9: empty filter proceeds after four banks; R1: entries start invalid
        lookup(0, ta, 5, "R1 R9 empty");
        // R3: fill then lookup from another core
        upd(1, 1, ta, 5, 2);
        lookup(0, ta, 5, "R3 fill forward");
        // R8: requester's own entry is ignored
        lookup(1, ta, 5, "R8 self ignored");
        // R6: partial match, differing full tag
        upd(2, 1, tp, 5, 0);
        lookup(0, tb, 5, "R6 partial only");
        // R7: priority, bank 1 visited first (set 5 -> start bank 1)
        upd(3, 1, ta, 5, 1);
        upd(2, 1, ta, 5, 1);
        lookup(0, ta, 5, "R7 first bank lowest core");
        lookup(2, ta, 5, "R7 R8 skip self");
        // R3: evictions
        upd(2, 0, ta, 5, 1);
        upd(3, 0, ta, 5, 1);
        upd(1, 0, ta, 5, 2);
        lookup(0, ta, 5, "R3 evict proceed");

        // R10: same-set fill into an already visited bank restarts the walk
        issue(0, tb, 8);
        @(negedge clk);
        upd_valid[3] = 1'b1; upd_fill[3] = 1'b1;
        upd_line[3*LINE_W +: LINE_W] = {tb, 4'd8};
        upd_way[3*2 +: 2] = 2'd0;
        @(posedge clk);
        m_vld[3][8][0] = 1; m_tag[3][8][0] = tb;
        @(negedge clk);
        upd_valid = '0;
        wait_done(cnt);
        check_res("R10 restart sees fill", 1, 3);
        @(negedge clk);

        // R10: different-set update leaves latency unchanged
        model(0, ta, 12, efwd, etgt, elat);
        issue(0, ta, 12);
        upd_valid[1] = 1'b1; upd_fill[1] = 1'b1;
        upd_line[1*LINE_W +: LINE_W] = {ta, 4'd13};
        upd_way[1*2 +: 2] = 2'd3;
        @(posedge clk);
        m_vld[1][13][3] = 1; m_tag[1][13][3] = ta;
        @(negedge clk);
        upd_valid = '0;
        cnt = 1;
        while (done !== 1'b1 && cnt < 60) begin
            @(negedge clk);
            cnt++;
        end
        check_res("R10 other set", efwd, etgt);
        chk(cnt == elat, "R10 other set latency", cnt, elat);
        @(negedge clk);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int st;
            st = sets[$urandom % 4];
            if ($urandom % 100 < 55)
                upd($urandom % CORES, ($urandom % 4) != 0, rnd_tag(), st, $urandom % 4);
            else
                lookup($urandom % CORES, rnd_tag(), st, "R3 R5 R7 random");
        end
        summary();
    end
endmodule